// File: doc/BRIEF.md
# Fault-Tolerant Tick Agreement Node

This block is a clocked model of one node in a fully connected group of nodes that agree on a shared, rising tick number. Up to F of the other nodes may behave arbitrarily and report any value at any time. The node has 3F+1 remote inputs, and each input carries a W-bit tick number with a one-cycle valid strobe. For each remote, the node stores the latest tick number it received.

Two voting rules act on the local tick counter. The adopt rule lets the node catch up to a tick that F+1 remotes have already passed. The advance rule moves the node one tick past a value that 2F+1 remotes have reached. Any F remotes together can never meet either threshold, so faulty peers cannot push the counter on their own. Each time the counter moves, the node broadcasts the new value once on its output strobe. After reset, it broadcasts tick 0 once.

The block is used as the decision core of a node. The links, handshakes and synchronizers of the network feed its remote inputs. Its broadcast output drives the links to the other nodes.

Top module: `tsync_node`

## Requirements
- R1: While reset is held, `tick_count` is 0 and `tx_valid` is 0. On the first clock edge after reset is released, the node pulses `tx_valid` for one cycle with `tx_tick` = 0. No rule can move the counter at that edge.
- R2: Each remote has one stored tick, and each strobe on `rx_valid[i]` replaces it with `rx_tick[i*W +: W]`. A remote counts at most once toward a threshold, however many strobes it sends.
- R3: Adopt rule. Let m1 be the largest value that at least F+1 reporting remotes hold or exceed. If m1 is strictly greater than the counter, the counter becomes m1.
- R4: Advance rule. Let m2 be the largest value that at least 2F+1 reporting remotes hold or exceed. If m2 is at least the counter, the counter becomes m2+1.
- R5: Any F remotes reporting large values cannot move the counter, whatever the other remotes report.
- R6: If both rules qualify at the same edge, the counter takes the larger of m1 and m2+1.
- R7: The counter never decreases. Every counter change comes with exactly one `tx_valid` pulse, and each broadcast value is strictly greater than the one before it, so no tick is ever sent twice.
- R8: A strobe that enables a rule changes `tick_count` at the second clock edge after the strobe is sampled. At that same edge, `tx_valid` pulses with `tx_tick` equal to the new `tick_count`.
- R9: The advance rule does not fire when m2 is the all-ones value. The counter stays at its maximum and never wraps to 0.
- R10: A remote that has not strobed since reset counts toward neither threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (boot) |
| rx_valid | input | 3F+1 | Per-remote strobe; bit i marks a new tick from remote i |
| rx_tick | input | (3F+1)*W | Remote tick numbers; remote i occupies bits i*W+W-1 down to i*W |
| tx_valid | output | 1 | One-cycle broadcast strobe |
| tx_tick | output | W | Tick number being broadcast |
| tick_count | output | W | Local tick counter |

## Verification
The bench runs with F=1 and W=4. Faulty remotes are modelled by one remote sending large values, including repeated strobes of growing values. A design that counted messages instead of remotes, or used the wrong threshold, would move the counter there. The bench walks the strict-versus-inclusive comparisons at the exact counter value, where a swapped comparison either misses an advance or adopts the current tick again. It also drives both rules in the same cycle, where picking the wrong winner leaves the counter one tick short. At the all-ones tick, a design without the guard would wrap the counter to 0 and broadcast it a second time. An exhaustive sweep over pairs of reported values compares the counter, the broadcast count and the last broadcast value against an arithmetic model.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_BOOT  = 2'd1,
    SRC_ADOPT = 2'd2,
    SRC_ADV   = 2'd3
  } tsync_src_e;
endpackage

// File: rtl/tsync_peer_store.sv
module tsync_peer_store #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          rx_valid,
  input  logic [N*W-1:0]        rx_tick,
  output logic [N-1:0]          heard,
  output logic [N-1:0][W-1:0]   vals
);
  for (genvar i = 0; i < N; i++) begin : g_peer
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        heard[i] <= 1'b0;
        vals[i]  <= '0;
      end else if (rx_valid[i]) begin
        heard[i] <= 1'b1;
        vals[i]  <= rx_tick[i*W +: W];
      end
    end
  end
endmodule

// File: rtl/tsync_vote.sv
module tsync_vote #(
  parameter int N = 4,
  parameter int W = 8,
  parameter int K = 2
) (
  input  logic [N-1:0]        heard,
  input  logic [N-1:0][W-1:0] vals,
  output logic                reach_ok,
  output logic [W-1:0]        reach_val
);
  // Number of heard remotes whose value is at or above v.
  function automatic int reach_count(input logic [N-1:0] h,
                                     input logic [N-1:0][W-1:0] v_all,
                                     input logic [W-1:0] v);
    int c;
    c = 0;
    for (int j = 0; j < N; j++) begin
      if (h[j] && (v_all[j] >= v)) c = c + 1;
    end
    return c;
  endfunction

  always_comb begin
    reach_ok  = 1'b0;
    reach_val = '0;
    for (int i = 0; i < N; i++) begin
      if (heard[i] && (reach_count(heard, vals, vals[i]) >= K)) begin
        if (!reach_ok || (vals[i] > reach_val)) begin
          reach_val = vals[i];
          reach_ok  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tsync_core.sv
module tsync_core
  import tsync_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adopt_ok,
  input  logic [W-1:0] m_adopt,
  input  logic         adv_ok,
  input  logic [W-1:0] m_adv,
  output logic         fire_adopt,
  output logic         fire_adv,
  output logic         boot_pend,
  output tsync_src_e   src,
  output logic         tx_valid,
  output logic [W-1:0] tx_tick,
  output logic [W-1:0] tick_count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] adv_next;
  logic [W-1:0] next_count;
  logic         take_adv;

  assign adv_next   = m_adv + 1'b1;
  assign fire_adopt = !boot_pend && adopt_ok && (m_adopt > tick_count);
  assign fire_adv   = !boot_pend && adv_ok && (m_adv >= tick_count) && (m_adv != TOP);
  assign take_adv   = fire_adv && (!fire_adopt || (adv_next > m_adopt));
  assign next_count = take_adv ? adv_next : m_adopt;

  always_comb begin
    if (boot_pend)       src = SRC_BOOT;
    else if (take_adv)   src = SRC_ADV;
    else if (fire_adopt) src = SRC_ADOPT;
    else                 src = SRC_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_pend  <= 1'b1;
      tick_count <= '0;
      tx_valid   <= 1'b0;
      tx_tick    <= '0;
    end else begin
      case (src)
        SRC_BOOT: begin
          boot_pend <= 1'b0;
          tx_valid  <= 1'b1;
          tx_tick   <= '0;
        end
        SRC_ADOPT, SRC_ADV: begin
          tick_count <= next_count;
          tx_valid   <= 1'b1;
          tx_tick    <= next_count;
        end
        default: tx_valid <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tsync_node.sv
module tsync_node
  import tsync_pkg::*;
#(
  parameter int F = 1,
  parameter int W = 8,
  localparam int N = 3*F + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   rx_valid,
  input  logic [N*W-1:0] rx_tick,
  output logic           tx_valid,
  output logic [W-1:0]   tx_tick,
  output logic [W-1:0]   tick_count
);
  localparam int K_ADOPT = F + 1;
  localparam int K_ADV   = 2*F + 1;

  logic [N-1:0]        heard;
  logic [N-1:0][W-1:0] vals;
  logic                adopt_ok, adv_ok;
  logic [W-1:0]        m_adopt, m_adv;
  logic                fire_adopt, fire_adv, boot_pend;
  tsync_src_e          src;

  tsync_peer_store #(.N(N), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_tick(rx_tick),
    .heard(heard), .vals(vals)
  );

  tsync_vote #(.N(N), .W(W), .K(K_ADOPT)) u_vote_adopt (
    .heard(heard), .vals(vals), .reach_ok(adopt_ok), .reach_val(m_adopt)
  );

  tsync_vote #(.N(N), .W(W), .K(K_ADV)) u_vote_adv (
    .heard(heard), .vals(vals), .reach_ok(adv_ok), .reach_val(m_adv)
  );

  tsync_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .adopt_ok(adopt_ok), .m_adopt(m_adopt), .adv_ok(adv_ok), .m_adv(m_adv),
    .fire_adopt(fire_adopt), .fire_adv(fire_adv), .boot_pend(boot_pend), .src(src),
    .tx_valid(tx_valid), .tx_tick(tx_tick), .tick_count(tick_count)
  );
endmodule

// File: rtl/tsync_node_chk.sv
module tsync_node_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_valid,
  input logic [W-1:0] tx_tick,
  input logic [W-1:0] tick_count,
  input logic         fire_adopt,
  input logic         fire_adv,
  input logic [W-1:0] m_adopt,
  input logic [W-1:0] m_adv,
  input logic         boot_pend
);
  logic         have_tx;
  logic [W-1:0] last_tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_tx <= 1'b0;
      last_tx <= '0;
    end else if (tx_valid) begin
      have_tx <= 1'b1;
      last_tx <= tx_tick;
    end
  end

  // R1: the very first broadcast carries tick 0
  p_boot_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !have_tx) |-> (tx_tick == '0));

  // R1: no rule acts during the boot edge
  p_boot_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    boot_pend |=> (tick_count == '0));

  // R3: adopt alone lands on m_adopt
  p_adopt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_adopt && !fire_adv) |=> (tick_count == $past(m_adopt)));

  // R4: advance alone lands one past m_adv
  p_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_adv && !fire_adopt) |=> (tick_count == $past(m_adv) + 1'b1));

  // R7: counter never falls
  p_monotone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tick_count >= $past(tick_count)));

  // R7: every counter change is broadcast
  p_change_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tick_count) |-> tx_valid);

  // R7: broadcasts strictly rise
  p_strict_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && have_tx) |-> (tx_tick > last_tx));

  // R8: broadcast value equals the counter
  p_tx_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_tick == tick_count));

  // R9: the counter never wraps back to zero
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_count != '0) |=> (tick_count != '0));
endmodule

bind tsync_node tsync_node_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_tick(tx_tick),
  .tick_count(tick_count), .fire_adopt(fire_adopt), .fire_adv(fire_adv),
  .m_adopt(m_adopt), .m_adv(m_adv), .boot_pend(boot_pend)
);

// File: tb/tsync_node_bench.sv
module tsync_node_bench;
  localparam int F = 1;
  localparam int W = 4;
  localparam int N = 3*F + 1;
  localparam int TOP = (1 << W) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   rx_valid = '0;
  logic [N*W-1:0] rx_tick = '0;
  logic           tx_valid;
  logic [W-1:0]   tx_tick;
  logic [W-1:0]   tick_count;

  int vectors = 0;
  int errors = 0;
  int tx_seen = 0;
  int tx_last = -1;
  bit done = 0;

  // bench model state
  bit m_heard [N];
  int m_val [N];
  int m_cnt;
  int m_txn;
  int m_txlast;

  always #2 clk = ~clk;

  tsync_node #(.F(F), .W(W)) u_tsync_node (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_tick(rx_tick),
    .tx_valid(tx_valid), .tx_tick(tx_tick), .tick_count(tick_count)
  );

  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      tx_seen = tx_seen + 1;
      tx_last = int'(tx_tick);
    end
  end

  function automatic int top_reach(input int k, output bit ok);
    ok = 0;
    for (int v = TOP; v >= 0; v--) begin
      int c;
      c = 0;
      for (int j = 0; j < N; j++) if (m_heard[j] && m_val[j] >= v) c++;
      if (c >= k) begin ok = 1; return v; end
    end
    return 0;
  endfunction

  task automatic model_settle();
    for (int it = 0; it < 40; it++) begin
      bit o1, o2;
      int a, b, nxt;
      bit f1, f2;
      a = top_reach(F+1, o1);
      b = top_reach(2*F+1, o2);
      f1 = o1 && a > m_cnt;
      f2 = o2 && b >= m_cnt && b < TOP;
      if (!f1 && !f2) break;
      nxt = 0;
      if (f1) nxt = a;
      if (f2 && b + 1 > nxt) nxt = b + 1;
      m_cnt = nxt;
      m_txn++;
      m_txlast = nxt;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " count"}, int'(tick_count), m_cnt);
    check({req, " txnum"}, tx_seen, m_txn);
    check({req, " txlast"}, tx_last, m_txlast);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rx_valid = '0;
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R1 reset count", int'(tick_count), 0);
    check("R1 reset tx", int'(tx_valid), 0);
    tx_seen = 0;
    tx_last = -1;
    for (int i = 0; i < N; i++) begin m_heard[i] = 0; m_val[i] = 0; end
    m_cnt = 0; m_txn = 1; m_txlast = 0;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  // strobe the remotes in mask with the given values in one cycle
  task automatic strobe(input logic [N-1:0] mask, input int v0, input int v1,
                        input int v2, input int v3);
    int v [N];
    v[0] = v0; v[1] = v1; v[2] = v2; v[3] = v3;
    @(negedge clk);
    rx_valid = mask;
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        rx_tick[i*W +: W] = W'(v[i]);
        m_heard[i] = 1;
        m_val[i] = v[i];
      end
    end
    @(negedge clk);
    rx_valid = '0;
    model_settle();
    for (int k = 0; k < 3; k++) @(negedge clk);
    #1;
  endtask

  initial begin
    do_reset();
    check_all("R1 boot");

    strobe(4'b0001, 5, 0, 0, 0);
    check_all("R5 one faulty remote");
    strobe(4'b0001, 9, 0, 0, 0);
    strobe(4'b0001, 11, 0, 0, 0);
    check_all("R2 repeated strobes count once");
    check("R10 unheard remotes", int'(tick_count), 0);

    strobe(4'b0010, 0, 3, 0, 0);
    check_all("R3 adopt");
    strobe(4'b0100, 0, 0, 3, 0);
    check_all("R4 advance inclusive");
    strobe(4'b1000, 0, 0, 0, 4);
    check_all("R3 strict no readopt");

    // R8 latency: at the first edge only the store updates, at the second the counter
    @(negedge clk);
    rx_valid = 4'b0010;
    rx_tick[1*W +: W] = W'(7);
    m_heard[1] = 1; m_val[1] = 7;
    @(negedge clk);
    rx_valid = '0;
    #1;
    check("R8 no change after one edge", int'(tick_count), 4);
    @(negedge clk);
    #1;
    check("R8 changed after two edges", int'(tick_count), 7);
    model_settle();
    check_all("R8 adopt 7");

    strobe(4'b0100, 0, 0, 7, 0);
    check_all("R4 advance to 8");

    strobe(4'b0111, 12, 12, 10, 0);
    check_all("R6 adopt wins");
    strobe(4'b1111, 13, 13, 13, 13);
    check_all("R6 advance wins");
    strobe(4'b1111, 15, 15, 15, 15);
    check_all("R9 reach top");
    for (int k = 0; k < 5; k++) @(negedge clk);
    #1;
    check_all("R9 no wrap");
    check("R7 single tx of top", tx_seen, m_txn);

    // R5: fresh start, one faulty remote at top value, others low
    do_reset();
    strobe(4'b1000, 0, 0, 0, TOP);
    strobe(4'b0001, 1, 0, 0, 0);
    check_all("R5 faulty plus one correct");

    // exhaustive pairs: remotes 0 and 2 report a, remote 1 reports b
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        do_reset();
        strobe(4'b0111, a, b, a, 0);
        check_all("R3 R4 R7 sweep");
      end
    end

    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule